// File: doc/BRIEF.md
# Steering Target Resolver

This block works out where a read of a replicated register should be sent. Many copies of such a register share one offset, and some copies sit in units that are fused off or powered down. A read aimed at one of those comes back as zero. The resolver takes a register offset and returns a group/instance pair that is sure to reach a live copy.

The resolver compares the offset against fixed tables of inclusive address ranges, one table per steering category. The categories are tried in a fixed priority order. The first category whose table holds the offset decides the result. Each category builds its pair in its own way:

- **L3-bank category:** the lowest present L3 bank.
- **Memory-slice category:** the lowest present memory slice.
- **Local-fabric category:** twice the lowest present memory slice.
- **Instance-zero category:** the fixed pair 0/0.

When no table matches, the resolver returns a programmable default pair. A request strobe starts a lookup. The answer comes back one cycle later, together with a valid pulse, the matched category and a warning bit. The warning bit flags a unit mask that is all zero, which should never happen.

Top module: `steer_target_resolver`

## Requirements
- R1: The offset is tested against each category's ranges, with both bounds inclusive. The categories are tried in the order L3-bank (code 0), memory-slice (code 1), local-fabric (code 2), instance-zero (code 3). The first category that contains the offset is reported on `rsp_cat`.
- R2: When no category contains the offset, `rsp_cat` is 4 and the outputs are `dflt_group` and `dflt_inst` as they were sampled with the request.
- R3: For the L3-bank category the group is 0. The instance is the index of the lowest set bit of the bank-present mask. That mask is the bitwise inverse of `bank_fuse[BANK_LSB +: NBANK]` (bit 1 means the bank is disabled). Fuse bits outside this field have no effect.
- R4: For the memory-slice category the group is the index of the lowest present slice and the instance is 0.
- R5: For the local-fabric category the group is twice the index of the lowest present slice and the instance is 0.
- R6: For the instance-zero category the group and the instance are both 0, whatever the masks hold.
- R7: Slice s counts as present when `meml3_en[s]` is 1 or when any bit of `ss_present[s*SS_PER_SLICE +: SS_PER_SLICE]` is 1.
- R8: A category configured with zero ranges never matches. Offsets inside it fall through to the categories after it, or to the default pair.
- R9: `rsp_warn` is 1 only when the matched category is L3-bank, memory-slice or local-fabric and the mask it uses is all zero. In that case the group and the instance are both 0.
- R10: The result is registered on the clock edge where `req_valid` is 1. `rsp_valid` is 1 for exactly the following cycle. Between requests the outputs hold their last value. Reset clears the outputs to category 4, group 0, instance 0, no warning and no valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup strobe |
| req_offset | input | OFS_W | Register offset to resolve |
| bank_fuse | input | FUSE_W | Fuse word holding the L3-bank disable field |
| meml3_en | input | NSLICE | Memory-L3 enable, one bit per slice |
| ss_present | input | NSLICE*SS_PER_SLICE | Subslice-present mask, grouped by quadrant |
| dflt_group | input | GRP_W | Default group for offsets that match no category |
| dflt_inst | input | INST_W | Default instance for offsets that match no category |
| rsp_valid | output | 1 | Result-valid pulse |
| rsp_group | output | GRP_W | Resolved group |
| rsp_inst | output | INST_W | Resolved instance |
| rsp_cat | output | 3 | Matched category code (0 to 3, or 4 for default) |
| rsp_warn | output | 1 | Matched category had an all-zero unit mask |

## Verification
Some properties are checked on every cycle:
- The valid pulse follows each strobe.
- The fixed-zero fields of each category hold.
- The local-fabric group is always even.
- The warning appears only together with a 0/0 pair.
- On an L3-bank result, the warning matches an empty bank mask one cycle earlier.
- A default result carries the default pair that was sampled with the request.

Other behaviours can only be shown by the bench's sweeps:
- Which category wins at each range bound.
- The exact lowest-bit index over every bank-field value and every slice combination.
- Fall-through past an empty table, and priority between overlapping tables. A second instance is configured with an empty memory-slice table and an instance-zero range that overlaps the other categories.

// File: rtl/steer_pkg.sv
package steer_pkg;
   localparam int MAX_RANGES = 4;
   localparam int CAT_W      = 3;

   typedef enum logic [CAT_W-1:0] {
      CAT_L3BANK  = 3'd0,
      CAT_MSLICE  = 3'd1,
      CAT_LNCF    = 3'd2,
      CAT_INST0   = 3'd3,
      CAT_DEFAULT = 3'd4
   } steer_cat_e;
endpackage

// File: rtl/steer_range_match.sv
module steer_range_match
   import steer_pkg::*;
#(
   parameter int                               OFS_W  = 24,
   parameter int                               NRANGE = 1,
   parameter logic [MAX_RANGES*OFS_W-1:0]      LO     = '0,
   parameter logic [MAX_RANGES*OFS_W-1:0]      HI     = '0
) (
   input  logic [OFS_W-1:0] offset,
   output logic             hit
);
   generate
      if (NRANGE < 0 || NRANGE > MAX_RANGES) begin : g_bad_count
         $error("steer_range_match: NRANGE outside 0..MAX_RANGES");
      end
      if (NRANGE == 0) begin : g_empty
         assign hit = 1'b0;
      end else begin : g_cmp
         logic [NRANGE-1:0] in_range;
         for (genvar r = 0; r < NRANGE; r++) begin : g_rng
            if (LO[r*OFS_W +: OFS_W] > HI[r*OFS_W +: OFS_W]) begin : g_bad_order
               $error("steer_range_match: range start above range end");
            end
            assign in_range[r] = (offset >= LO[r*OFS_W +: OFS_W]) &&
                                 (offset <= HI[r*OFS_W +: OFS_W]);
         end
         assign hit = |in_range;
      end
   endgenerate
endmodule

// File: rtl/steer_lowbit.sv
module steer_lowbit #(
   parameter int W  = 8,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          found
);
   generate
      if (W < 1) begin : g_bad_w
         $error("steer_lowbit: W must be at least 1");
      end
   endgenerate

   always_comb begin
      idx   = '0;
      found = 1'b0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) begin
            idx   = IW'(i);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/steer_target_resolver.sv
module steer_target_resolver
   import steer_pkg::*;
#(
   parameter int OFS_W        = 24,
   parameter int GRP_W        = 6,
   parameter int INST_W       = 6,
   parameter int FUSE_W       = 16,
   parameter int BANK_LSB     = 4,
   parameter int NBANK        = 8,
   parameter int NSLICE       = 4,
   parameter int SS_PER_SLICE = 4,
   parameter int L3_CNT = 1,
   parameter logic [MAX_RANGES*OFS_W-1:0] L3_LO = {24'h0, 24'h0, 24'h0, 24'h00B100},
   parameter logic [MAX_RANGES*OFS_W-1:0] L3_HI = {24'h0, 24'h0, 24'h0, 24'h00B3FF},
   parameter int MS_CNT = 4,
   parameter logic [MAX_RANGES*OFS_W-1:0] MS_LO = {24'h00E900, 24'h00DD00, 24'h00C800, 24'h004000},
   parameter logic [MAX_RANGES*OFS_W-1:0] MS_HI = {24'h00FFFF, 24'h00DDFF, 24'h00CFFF, 24'h004AFF},
   parameter int LN_CNT = 2,
   parameter logic [MAX_RANGES*OFS_W-1:0] LN_LO = {24'h0, 24'h0, 24'h00D800, 24'h00B000},
   parameter logic [MAX_RANGES*OFS_W-1:0] LN_HI = {24'h0, 24'h0, 24'h00D8FF, 24'h00B0FF},
   parameter int I0_CNT = 1,
   parameter logic [MAX_RANGES*OFS_W-1:0] I0_LO = {24'h0, 24'h0, 24'h0, 24'h008800},
   parameter logic [MAX_RANGES*OFS_W-1:0] I0_HI = {24'h0, 24'h0, 24'h0, 24'h00887F}
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           req_valid,
   input  logic [OFS_W-1:0]               req_offset,
   input  logic [FUSE_W-1:0]              bank_fuse,
   input  logic [NSLICE-1:0]              meml3_en,
   input  logic [NSLICE*SS_PER_SLICE-1:0] ss_present,
   input  logic [GRP_W-1:0]               dflt_group,
   input  logic [INST_W-1:0]              dflt_inst,
   output logic                           rsp_valid,
   output logic [GRP_W-1:0]               rsp_group,
   output logic [INST_W-1:0]              rsp_inst,
   output logic [CAT_W-1:0]               rsp_cat,
   output logic                           rsp_warn
);
   localparam int BIW = (NBANK > 1) ? $clog2(NBANK) : 1;
   localparam int SIW = (NSLICE > 1) ? $clog2(NSLICE) : 1;

   generate
      if (BANK_LSB < 0 || BANK_LSB + NBANK > FUSE_W) begin : g_bad_field
         $error("steer_target_resolver: bank field outside fuse word");
      end
      if (INST_W < BIW) begin : g_bad_inst
         $error("steer_target_resolver: INST_W too narrow for bank index");
      end
      if (GRP_W < SIW + 1) begin : g_bad_grp
         $error("steer_target_resolver: GRP_W too narrow for doubled slice index");
      end
   endgenerate

   // ---- availability masks ----
   logic [NBANK-1:0]  bank_present;
   logic [NSLICE-1:0] slice_present;
   logic              unused_fuse_bits;

   assign bank_present     = ~bank_fuse[BANK_LSB +: NBANK];
   assign unused_fuse_bits = ^bank_fuse;

   generate
      for (genvar s = 0; s < NSLICE; s++) begin : g_slice
         assign slice_present[s] = meml3_en[s] |
                                   (|ss_present[s*SS_PER_SLICE +: SS_PER_SLICE]);
      end
   endgenerate

   logic [BIW-1:0] bank_idx;
   logic           bank_found;
   logic [SIW-1:0] slice_idx;
   logic           slice_found;

   steer_lowbit #(.W(NBANK))  u_bank_low  (.vec(bank_present),  .idx(bank_idx),  .found(bank_found));
   steer_lowbit #(.W(NSLICE)) u_slice_low (.vec(slice_present), .idx(slice_idx), .found(slice_found));

   // ---- range tables, one per category ----
   logic hit_l3, hit_ms, hit_ln, hit_i0;

   steer_range_match #(.OFS_W(OFS_W), .NRANGE(L3_CNT), .LO(L3_LO), .HI(L3_HI))
      u_rng_l3 (.offset(req_offset), .hit(hit_l3));
   steer_range_match #(.OFS_W(OFS_W), .NRANGE(MS_CNT), .LO(MS_LO), .HI(MS_HI))
      u_rng_ms (.offset(req_offset), .hit(hit_ms));
   steer_range_match #(.OFS_W(OFS_W), .NRANGE(LN_CNT), .LO(LN_LO), .HI(LN_HI))
      u_rng_ln (.offset(req_offset), .hit(hit_ln));
   steer_range_match #(.OFS_W(OFS_W), .NRANGE(I0_CNT), .LO(I0_LO), .HI(I0_HI))
      u_rng_i0 (.offset(req_offset), .hit(hit_i0));

   // ---- priority select ----
   logic [GRP_W-1:0]  nxt_group;
   logic [INST_W-1:0] nxt_inst;
   steer_cat_e        nxt_cat;
   logic              nxt_warn;

   always_comb begin
      nxt_group = dflt_group;
      nxt_inst  = dflt_inst;
      nxt_cat   = CAT_DEFAULT;
      nxt_warn  = 1'b0;
      if (hit_l3) begin
         nxt_cat   = CAT_L3BANK;
         nxt_group = '0;
         nxt_inst  = bank_found ? INST_W'(bank_idx) : '0;
         nxt_warn  = ~bank_found;
      end else if (hit_ms) begin
         nxt_cat   = CAT_MSLICE;
         nxt_group = slice_found ? GRP_W'(slice_idx) : '0;
         nxt_inst  = '0;
         nxt_warn  = ~slice_found;
      end else if (hit_ln) begin
         nxt_cat   = CAT_LNCF;
         nxt_group = slice_found ? GRP_W'({slice_idx, 1'b0}) : '0;
         nxt_inst  = '0;
         nxt_warn  = ~slice_found;
      end else if (hit_i0) begin
         nxt_cat   = CAT_INST0;
         nxt_group = '0;
         nxt_inst  = '0;
      end
   end

   // ---- result register ----
   steer_cat_e cat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_group <= '0;
         rsp_inst  <= '0;
         cat_q     <= CAT_DEFAULT;
         rsp_warn  <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_group <= nxt_group;
            rsp_inst  <= nxt_inst;
            cat_q     <= nxt_cat;
            rsp_warn  <= nxt_warn;
         end
      end
   end

   assign rsp_cat = cat_q;

   // ---- assertions ----
   a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r10_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(rsp_group) && $stable(rsp_inst) && $stable(rsp_cat));
   a_r9_warn_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_warn |-> (rsp_group == '0) && (rsp_inst == '0));
   a_r9_warn_cat: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_warn |-> (cat_q == CAT_L3BANK) || (cat_q == CAT_MSLICE) || (cat_q == CAT_LNCF));
   a_r9_l3_warn_mask: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && (cat_q == CAT_L3BANK) |-> rsp_warn == ($past(bank_present) == '0));
   a_r3_l3_group: assert property (@(posedge clk) disable iff (!rst_n)
      (cat_q == CAT_L3BANK) |-> rsp_group == '0);
   a_r4_ms_inst: assert property (@(posedge clk) disable iff (!rst_n)
      (cat_q == CAT_MSLICE) |-> rsp_inst == '0);
   a_r5_ln_even: assert property (@(posedge clk) disable iff (!rst_n)
      (cat_q == CAT_LNCF) |-> (rsp_group[0] == 1'b0) && (rsp_inst == '0));
   a_r6_inst0_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cat_q == CAT_INST0) |-> (rsp_group == '0) && (rsp_inst == '0));
   a_r2_default_pair: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && (cat_q == CAT_DEFAULT) |->
         (rsp_group == $past(dflt_group)) && (rsp_inst == $past(dflt_inst)));
endmodule

// File: tb/steer_target_resolver_tb.sv
`timescale 1ns/1ps
module steer_target_resolver_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [23:0] req_offset = '0;
   logic [15:0] bank_fuse = '0;
   logic [3:0]  meml3_en = '0;
   logic [15:0] ss_present = '0;
   logic [5:0]  dflt_group = '0;
   logic [5:0]  dflt_inst = '0;

   logic       m_valid, a_valid, m_warn, a_warn;
   logic [5:0] m_group, m_inst, a_group, a_inst;
   logic [2:0] m_cat, a_cat;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   steer_target_resolver u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
      .bank_fuse(bank_fuse), .meml3_en(meml3_en), .ss_present(ss_present),
      .dflt_group(dflt_group), .dflt_inst(dflt_inst),
      .rsp_valid(m_valid), .rsp_group(m_group), .rsp_inst(m_inst),
      .rsp_cat(m_cat), .rsp_warn(m_warn));

   // empty memory-slice table; instance-zero range overlaps L3-bank and local-fabric
   steer_target_resolver #(
      .MS_CNT(0),
      .I0_LO({24'h0, 24'h0, 24'h0, 24'h00B000}),
      .I0_HI({24'h0, 24'h0, 24'h0, 24'h00B3FF})
   ) u_dut_alt (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
      .bank_fuse(bank_fuse), .meml3_en(meml3_en), .ss_present(ss_present),
      .dflt_group(dflt_group), .dflt_inst(dflt_inst),
      .rsp_valid(a_valid), .rsp_group(a_group), .rsp_inst(a_inst),
      .rsp_cat(a_cat), .rsp_warn(a_warn));

   function automatic bit inr(input logic [23:0] off, input logic [23:0] lo, input logic [23:0] hi);
      return (off >= lo) && (off <= hi);
   endfunction

   // expected {valid, cat, warn, group, inst}
   function automatic logic [16:0] model(input bit alt, input logic [23:0] off);
      logic [7:0] bank;
      logic [3:0] slc;
      int lb, ls;
      bit h_l3, h_ms, h_ln, h_i0;
      bank = ~bank_fuse[11:4];
      for (int s = 0; s < 4; s++) slc[s] = meml3_en[s] | (ss_present[s*4 +: 4] != 4'h0);
      lb = -1;
      for (int k = 7; k >= 0; k--) if (bank[k]) lb = k;
      ls = -1;
      for (int k = 3; k >= 0; k--) if (slc[k]) ls = k;
      h_l3 = inr(off, 24'hB100, 24'hB3FF);
      h_ms = !alt && (inr(off, 24'h4000, 24'h4AFF) || inr(off, 24'hC800, 24'hCFFF) ||
                      inr(off, 24'hDD00, 24'hDDFF) || inr(off, 24'hE900, 24'hFFFF));
      h_ln = inr(off, 24'hB000, 24'hB0FF) || inr(off, 24'hD800, 24'hD8FF);
      h_i0 = alt ? inr(off, 24'hB000, 24'hB3FF) : inr(off, 24'h8800, 24'h887F);
      if (h_l3)      return (lb < 0) ? {1'b1, 3'd0, 1'b1, 12'd0} : {1'b1, 3'd0, 1'b0, 6'd0, 6'(lb)};
      else if (h_ms) return (ls < 0) ? {1'b1, 3'd1, 1'b1, 12'd0} : {1'b1, 3'd1, 1'b0, 6'(ls), 6'd0};
      else if (h_ln) return (ls < 0) ? {1'b1, 3'd2, 1'b1, 12'd0} : {1'b1, 3'd2, 1'b0, 6'(2*ls), 6'd0};
      else if (h_i0) return {1'b1, 3'd3, 1'b0, 12'd0};
      return {1'b1, 3'd4, 1'b0, dflt_group, dflt_inst};
   endfunction

   task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [23:0] off, input string tag);
      @(negedge clk);
      req_valid  = 1'b1;
      req_offset = off;
      @(negedge clk);
      req_valid = 1'b0;
      check({tag, " main"}, {m_valid, m_cat, m_warn, m_group, m_inst}, model(1'b0, off));
      check({tag, " alt"},  {a_valid, a_cat, a_warn, a_group, a_inst}, model(1'b1, off));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [16:0] held;
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 reset", {m_valid, m_cat, m_warn, m_group, m_inst}, {1'b0, 3'd4, 1'b0, 12'd0});
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R8: range bounds and priority
      bank_fuse = 16'h0000; meml3_en = 4'b0100; ss_present = 16'h0;
      dflt_group = 6'h15; dflt_inst = 6'h2A;
      foreach (bounds[i]) issue(bounds[i], "R1 R8");

      // R3 R9: every bank-field value, foreign fuse bits set
      for (int bf = 0; bf < 256; bf++) begin
         bank_fuse = {4'hA, 8'(bf), 4'h5};
         issue(24'h00B200, "R3 R9");
      end

      // R4 R5 R7 R9: all meml3 enables against per-quadrant subslice patterns
      bank_fuse = 16'h0;
      for (int m = 0; m < 16; m++) begin
         for (int q = 0; q < 16; q++) begin
            meml3_en   = 4'(m);
            ss_present = '0;
            for (int k = 0; k < 4; k++) ss_present[k*4 + ((k + q) % 4)] = q[k];
            issue(24'h00C900, "R4 R7 R9");
            issue(24'h00D880, "R5 R7 R9");
         end
      end

      // R6: instance-zero is unaffected by empty masks
      bank_fuse = 16'hFFFF; meml3_en = '0; ss_present = '0;
      issue(24'h008800, "R6");
      issue(24'h00887F, "R6");
      issue(24'h00B000, "R6 R9");

      // R2: default pair under several values
      bank_fuse = 16'h0; meml3_en = 4'b1000;
      for (int d = 0; d < 8; d++) begin
         dflt_group = 6'(d * 9);
         dflt_inst  = 6'(63 - d * 5);
         issue(24'(d * 24'h1F3D7), "R2");
      end
      issue(24'hFFFFFF, "R2");
      issue(24'h004500, "R2 R8");

      // R10: outputs hold and valid drops after the pulse
      issue(24'h00B180, "R10");
      held = {1'b0, m_cat, m_warn, m_group, m_inst};
      req_offset = 24'h000000;
      dflt_group = 6'h3F;
      @(negedge clk);
      check("R10 hold", {m_valid, m_cat, m_warn, m_group, m_inst}, held);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   logic [23:0] bounds [0:31] = '{
      24'h00B0FF, 24'h00B100, 24'h00B3FF, 24'h00B400,
      24'h003FFF, 24'h004000, 24'h004AFF, 24'h004B00,
      24'h00C7FF, 24'h00C800, 24'h00CFFF, 24'h00D000,
      24'h00DCFF, 24'h00DD00, 24'h00DDFF, 24'h00DE00,
      24'h00E8FF, 24'h00E900, 24'h00FFFF, 24'h010000,
      24'h00AFFF, 24'h00B000, 24'h00D7FF, 24'h00D800,
      24'h00D8FF, 24'h00D900, 24'h0087FF, 24'h008800,
      24'h00887F, 24'h008880, 24'h00B0FF, 24'h00B3FF
   };
endmodule